// File: doc/BRIEF.md
# Typed Control and Status Register Bank

This block is a small bank of byte-wide registers reached over a simple request/acknowledge bus. The initiator raises a request line with a write flag, a 16-bit address and write data. The bank answers with a registered one-cycle acknowledge pulse, and with read data for reads. Each register sits at its own fixed offset, and each has its own behaviour towards hardware. There is a plain setting, a saturating event counter, a set of interrupt status bits that software clears by writing ones, a mask for those bits, a set-by-software/clear-by-hardware control byte, a command byte that pulses a strobe when written, and a status input that pulses a strobe when read.

Hardware logic next to the bank sees the register contents on output ports. It feeds in increment, set, clear and status values, and it gets single-cycle strobes for the access side effects. An active-low interrupt line summarises the unmasked interrupt status bits.

Top module: `csr_bank`

## Requirements
- R1: A register is selected only when the request line is high and all 16 address bits equal its offset: setting 0, counter 1, interrupt status 2, interrupt mask 3, control 4, command 5, status input 6. A read of any other address returns 0. A write to any other address changes no register.
- R2: The acknowledge is registered. It rises one cycle after the request is first seen high, and it is never high for two cycles in a row.
- R3: After reset the setting register holds its default (parameter CFG_INIT), the mask holds MASK_INIT, the command byte holds CMD_INIT, and the counter, status bits and control byte hold 0. A write loads the write data.
- R4: The counter adds 1 on each clock edge where its increment input is high. A write to the counter takes priority over an increment in the same cycle.
- R5: The counter stays at all ones when it is incremented while at all ones.
- R6: On each clock edge, every interrupt status bit whose set input is high becomes 1. Writing a 1 to a status bit clears it, and this clear wins over a set of the same bit in the same cycle. Writing a 0 leaves the bit unchanged.
- R7: The interrupt line is low only when some status bit is 1 and its mask bit is 0, where mask bit 1 means masked. It follows the status and mask through one register stage.
- R8: Writing 1-bits to the control byte sets those bits. The hardware clear input clears bits, and a clear wins over a set of the same bit.
- R9: The command strobe pulses for exactly one cycle per write access to the command register. Reads of that register do not pulse it.
- R10: The status strobe pulses for exactly one cycle per read access to the status register, and that read returns the status input. Writes to that offset do not pulse it.
- R11: After reset the acknowledge and both strobes are low and the interrupt line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_irdy | input | 1 | Request from the initiator, held until acknowledged |
| bus_trdy | output | 1 | One-cycle acknowledge |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid while acknowledge is high |
| cfg_q | output | DATA_W | Setting register contents |
| cnt_inc | input | 1 | Counter increment request |
| cnt_q | output | DATA_W | Counter contents |
| irq_set | input | DATA_W | Per-bit interrupt set inputs |
| irq_n | output | 1 | Interrupt line, active low |
| ctl_clr | input | DATA_W | Per-bit hardware clear of the control byte |
| ctl_q | output | DATA_W | Control byte contents |
| cmd_q | output | DATA_W | Command byte contents |
| cmd_wstb | output | 1 | Command write strobe |
| sts_in | input | DATA_W | Status value returned on reads of offset 6 |
| sts_rstb | output | 1 | Status read strobe |

## Verification
The hardest case is a hardware event that collides with a software access to the same bit. Examples are an interrupt set arriving while software writes a 1 to clear that bit, a counter increment during a counter write, and a hardware clear during a control write. The directed tasks raise the hardware input on the cycle before the request and hold it through both edges where the write select is live. Each collision is therefore settled in favour of the winning side on every edge. The bench also counts strobe pulses over each whole access, so a strobe that fires on both select cycles, rather than only the acknowledged one, shows up as a count of two.

// File: rtl/csr_pkg.sv
package csr_pkg;
  // Register offsets; the bus decode and the read mux both rely on these.
  localparam int OFF_CFG  = 0;
  localparam int OFF_CNT  = 1;
  localparam int OFF_IRQ  = 2;
  localparam int OFF_MASK = 3;
  localparam int OFF_CTL  = 4;
  localparam int OFF_CMD  = 5;
  localparam int OFF_STS  = 6;
  localparam int NREGS    = 7;
endpackage

// File: rtl/csr_bus_if.sv
module csr_bus_if #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int NREGS  = 7,
  parameter bit REG_RD = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    irdy,
  input  logic                    wr,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [NREGS*DATA_W-1:0] rd_words,
  output logic                    trdy,
  output logic [DATA_W-1:0]       rd_data,
  output logic [NREGS-1:0]        rd_sel,
  output logic [NREGS-1:0]        wr_sel
);
  logic              trdy_nxt;
  logic [DATA_W-1:0] rd_mux;

  // Acknowledge: drop after one cycle, otherwise follow the request.
  assign trdy_nxt = trdy ? 1'b0 : irdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trdy <= 1'b0;
    else        trdy <= trdy_nxt;
  end

  // Full-width address compare per register.
  for (genvar i = 0; i < NREGS; i++) begin : g_dec
    logic hit;
    assign hit       = irdy && (addr == ADDR_W'(i));
    assign rd_sel[i] = hit && !wr;
    assign wr_sel[i] = hit && wr;
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NREGS; i++)
      if (rd_sel[i]) rd_mux = rd_words[i*DATA_W +: DATA_W];
  end

  if (REG_RD) begin : g_rd_reg
    logic [DATA_W-1:0] rd_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rd_q <= '0;
      else if (trdy_nxt) rd_q <= rd_mux;
    end
    assign rd_data = rd_q;
  end else begin : g_rd_comb
    assign rd_data = rd_mux;
  end
endmodule

// File: rtl/csr_irq.sv
module csr_irq #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] stat,
  output logic              pend
);
  // Sticky bits; a written one clears and beats a set on the same bit.
  function automatic logic [DATA_W-1:0] w1c_next(
    input logic [DATA_W-1:0] s, input logic [DATA_W-1:0] cur,
    input logic w, input logic [DATA_W-1:0] d);
    return (s | cur) & ~({DATA_W{w}} & d);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      pend <= 1'b0;
    end else begin
      stat <= w1c_next(set, stat, wr_sel, wdata);
      pend <= |(stat & ~mask);
    end
  end
endmodule

// File: rtl/csr_bank.sv
module csr_bank import csr_pkg::*; #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter bit          REG_RD    = 1'b0,
  parameter logic [7:0]  CFG_INIT  = 8'h00,
  parameter logic [7:0]  MASK_INIT = 8'hFF,
  parameter logic [7:0]  CMD_INIT  = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_irdy,
  output logic              bus_trdy,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] cfg_q,
  input  logic              cnt_inc,
  output logic [DATA_W-1:0] cnt_q,
  input  logic [DATA_W-1:0] irq_set,
  output logic              irq_n,
  input  logic [DATA_W-1:0] ctl_clr,
  output logic [DATA_W-1:0] ctl_q,
  output logic [DATA_W-1:0] cmd_q,
  output logic              cmd_wstb,
  input  logic [DATA_W-1:0] sts_in,
  output logic              sts_rstb
);
  localparam int WORDS_W = NREGS * DATA_W;

  logic [WORDS_W-1:0] rd_words;
  logic [NREGS-1:0]   rd_sel, wr_sel;
  logic [DATA_W-1:0]  mask_q, irq_stat;
  logic               irq_pend;

  // Named events for the checker.
  logic cnt_wr_ev, irq_wr_ev, ctl_wr_ev, cmd_wr_ev, sts_rd_ev;
  assign cnt_wr_ev = wr_sel[OFF_CNT];
  assign irq_wr_ev = wr_sel[OFF_IRQ];
  assign ctl_wr_ev = wr_sel[OFF_CTL];
  assign cmd_wr_ev = wr_sel[OFF_CMD];
  assign sts_rd_ev = rd_sel[OFF_STS];

  logic unused_sel;
  assign unused_sel = ^{rd_sel[OFF_CMD:OFF_CFG], wr_sel[OFF_STS]};

  function automatic logic [DATA_W-1:0] sat_inc(
    input logic [DATA_W-1:0] cur, input logic inc);
    return (inc && (cur != '1)) ? cur + 1'b1 : cur;
  endfunction

  function automatic logic [DATA_W-1:0] soft_next(
    input logic [DATA_W-1:0] cur, input logic w,
    input logic [DATA_W-1:0] d, input logic [DATA_W-1:0] clr);
    return (cur | ({DATA_W{w}} & d)) & ~clr;
  endfunction

  csr_bus_if #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREGS(NREGS), .REG_RD(REG_RD)
  ) u_bus (
    .clk(clk), .rst_n(rst_n), .irdy(bus_irdy), .wr(bus_wr), .addr(bus_addr),
    .rd_words(rd_words), .trdy(bus_trdy), .rd_data(bus_rdata),
    .rd_sel(rd_sel), .wr_sel(wr_sel)
  );

  csr_irq #(.DATA_W(DATA_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .set(irq_set), .wr_sel(irq_wr_ev),
    .wdata(bus_wdata), .mask(mask_q), .stat(irq_stat), .pend(irq_pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= DATA_W'(CFG_INIT);
      mask_q   <= DATA_W'(MASK_INIT);
      cmd_q    <= DATA_W'(CMD_INIT);
      cnt_q    <= '0;
      ctl_q    <= '0;
      cmd_wstb <= 1'b0;
      sts_rstb <= 1'b0;
    end else begin
      if (wr_sel[OFF_CFG])  cfg_q  <= bus_wdata;
      if (wr_sel[OFF_MASK]) mask_q <= bus_wdata;
      if (cmd_wr_ev)        cmd_q  <= bus_wdata;
      cnt_q    <= cnt_wr_ev ? bus_wdata : sat_inc(cnt_q, cnt_inc);
      ctl_q    <= soft_next(ctl_q, ctl_wr_ev, bus_wdata, ctl_clr);
      cmd_wstb <= cmd_wr_ev && bus_trdy;
      sts_rstb <= sts_rd_ev && bus_trdy;
    end
  end

  assign irq_n = ~irq_pend;

  assign rd_words[OFF_CFG*DATA_W  +: DATA_W] = cfg_q;
  assign rd_words[OFF_CNT*DATA_W  +: DATA_W] = cnt_q;
  assign rd_words[OFF_IRQ*DATA_W  +: DATA_W] = irq_stat;
  assign rd_words[OFF_MASK*DATA_W +: DATA_W] = mask_q;
  assign rd_words[OFF_CTL*DATA_W  +: DATA_W] = ctl_q;
  assign rd_words[OFF_CMD*DATA_W  +: DATA_W] = cmd_q;
  assign rd_words[OFF_STS*DATA_W  +: DATA_W] = sts_in;
endmodule

// File: rtl/csr_bank_chk.sv
module csr_bank_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irdy,
  input logic              trdy,
  input logic [DATA_W-1:0] cnt_q,
  input logic              cnt_wr,
  input logic [DATA_W-1:0] irq_stat,
  input logic              irq_wr,
  input logic [DATA_W-1:0] irq_mask,
  input logic              irq_n,
  input logic [DATA_W-1:0] ctl_q,
  input logic [DATA_W-1:0] ctl_clr,
  input logic              cmd_wstb,
  input logic              sts_rstb
);
  a_r2_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    trdy |=> !trdy);
  a_r2_ack_answers: assert property (@(posedge clk) disable iff (!rst_n)
    (irdy && !trdy) |=> trdy);
  a_r5_cnt_holds_max: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == '1) && !cnt_wr) |=> (cnt_q == '1));
  a_r6_bits_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_wr |=> (($past(irq_stat) & ~irq_stat) == '0));
  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_stat & ~irq_mask) == '0) |=> irq_n);
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_clr != '0) |=> ((ctl_q & $past(ctl_clr)) == '0));
  a_r9_wstb_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wstb |=> !cmd_wstb);
  a_r10_rstb_single: assert property (@(posedge clk) disable iff (!rst_n)
    sts_rstb |=> !sts_rstb);
endmodule

bind csr_bank csr_bank_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irdy(bus_irdy), .trdy(bus_trdy),
  .cnt_q(cnt_q), .cnt_wr(cnt_wr_ev), .irq_stat(irq_stat), .irq_wr(irq_wr_ev),
  .irq_mask(mask_q), .irq_n(irq_n), .ctl_q(ctl_q), .ctl_clr(ctl_clr),
  .cmd_wstb(cmd_wstb), .sts_rstb(sts_rstb)
);

// File: tb/csr_bank_test.sv
module csr_bank_test;
  localparam int AW = 16;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_irdy = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic bus_trdy, irq_n, cmd_wstb, sts_rstb;
  logic [DW-1:0] bus_rdata, cfg_q, cnt_q, ctl_q, cmd_q;
  logic cnt_inc = 1'b0;
  logic [DW-1:0] irq_set = '0, ctl_clr = '0, sts_in = '0;

  int checks = 0, fails = 0;
  int wstb_cnt = 0, rstb_cnt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  csr_bank #(.ADDR_W(AW), .DATA_W(DW), .REG_RD(1'b0),
             .CFG_INIT(8'hA5), .MASK_INIT(8'hFF), .CMD_INIT(8'h00)) uut (
    .clk(clk), .rst_n(rst_n), .bus_irdy(bus_irdy), .bus_trdy(bus_trdy),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cfg_q(cfg_q), .cnt_inc(cnt_inc), .cnt_q(cnt_q),
    .irq_set(irq_set), .irq_n(irq_n), .ctl_clr(ctl_clr), .ctl_q(ctl_q),
    .cmd_q(cmd_q), .cmd_wstb(cmd_wstb), .sts_in(sts_in), .sts_rstb(sts_rstb));

  always @(negedge clk) begin
    if (cmd_wstb) wstb_cnt++;
    if (sts_rstb) rstb_cnt++;
  end

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // One access; returns read data and the number of cycles to the acknowledge.
  task automatic xfer(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      output logic [DW-1:0] rd, output int lat);
    @(negedge clk);
    bus_irdy = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!bus_trdy && lat < 20);
    rd = bus_rdata;
    @(negedge clk);
    bus_irdy = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wr_reg(input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] r; int l;
    xfer(1'b1, a, d, r, l);
  endtask

  task automatic rd_reg(input logic [AW-1:0] a, output logic [DW-1:0] r);
    int l;
    xfer(1'b0, a, '0, r, l);
  endtask

  task automatic t_reset;
    check("R11 ack", {7'b0, bus_trdy}, 8'h00);
    check("R11 irq_n", {7'b0, irq_n}, 8'h01);
    check("R11 strobes", {6'b0, cmd_wstb, sts_rstb}, 8'h00);
    check("R3 cfg default", cfg_q, 8'hA5);
    check("R3 cnt reset", cnt_q, 8'h00);
    check("R3 ctl reset", ctl_q, 8'h00);
  endtask

  task automatic t_ready;
    logic [DW-1:0] r; int l;
    @(negedge clk);
    bus_irdy = 1'b1; bus_addr = 16'd0;
    l = 0;
    do begin @(negedge clk); l++; end while (!bus_trdy && l < 20);
    check("R2 ack latency", 8'(l), 8'd1);
    @(negedge clk);
    check("R2 ack one cycle", {7'b0, bus_trdy}, 8'h00);
    bus_irdy = 1'b0;
    xfer(1'b0, 16'd0, '0, r, l);
    check("R2 ack latency read", 8'(l), 8'd1);
  endtask

  task automatic t_decode;
    logic [DW-1:0] r;
    wr_reg(16'd0, 8'h3C);
    check("R3 cfg write", cfg_q, 8'h3C);
    rd_reg(16'd0, r);
    check("R1 read cfg", r, 8'h3C);
    wr_reg(16'h0100, 8'h55);
    check("R1 alias write ignored", cfg_q, 8'h3C);
    rd_reg(16'h0100, r);
    check("R1 unmapped read", r, 8'h00);
    rd_reg(16'd7, r);
    check("R1 past-end read", r, 8'h00);
  endtask

  task automatic t_counter;
    logic [DW-1:0] r;
    wr_reg(16'd1, 8'h03);
    @(negedge clk); cnt_inc = 1'b1;
    repeat (5) @(negedge clk);
    cnt_inc = 1'b0;
    check("R4 count", cnt_q, 8'h08);
    wr_reg(16'd1, 8'hFD);
    @(negedge clk); cnt_inc = 1'b1;
    repeat (5) @(negedge clk);
    cnt_inc = 1'b0;
    check("R5 saturate", cnt_q, 8'hFF);
    rd_reg(16'd1, r);
    check("R5 saturate read", r, 8'hFF);
    @(negedge clk); cnt_inc = 1'b1;
    wr_reg(16'd1, 8'h10);
    cnt_inc = 1'b0;
    check("R4 write beats inc", cnt_q, 8'h10);
  endtask

  task automatic t_irq;
    logic [DW-1:0] r;
    @(negedge clk); irq_set = 8'h03;
    wr_reg(16'd2, 8'h01);
    irq_set = 8'h00;
    @(negedge clk);
    rd_reg(16'd2, r);
    check("R6 clear beats set", r, 8'h02);
    repeat (2) @(negedge clk);
    check("R7 masked", {7'b0, irq_n}, 8'h01);
    wr_reg(16'd3, 8'h00);
    repeat (2) @(negedge clk);
    check("R7 unmasked", {7'b0, irq_n}, 8'h00);
    wr_reg(16'd3, 8'h02);
    repeat (2) @(negedge clk);
    check("R7 bit masked", {7'b0, irq_n}, 8'h01);
    wr_reg(16'd3, 8'h00);
    wr_reg(16'd2, 8'h00);
    rd_reg(16'd2, r);
    check("R6 zero write keeps", r, 8'h02);
    wr_reg(16'd2, 8'h02);
    rd_reg(16'd2, r);
    check("R6 w1c", r, 8'h00);
    repeat (2) @(negedge clk);
    check("R7 cleared", {7'b0, irq_n}, 8'h01);
  endtask

  task automatic t_ctl;
    @(negedge clk); ctl_clr = 8'h03;
    wr_reg(16'd4, 8'h0F);
    ctl_clr = 8'h00;
    @(negedge clk);
    check("R8 clear beats set", ctl_q, 8'h0C);
    ctl_clr = 8'h04;
    @(negedge clk);
    ctl_clr = 8'h00;
    check("R8 hw clear", ctl_q, 8'h08);
    wr_reg(16'd4, 8'h01);
    check("R8 or-in", ctl_q, 8'h09);
  endtask

  task automatic t_strobes;
    logic [DW-1:0] r; int w0, r0;
    repeat (2) @(negedge clk);
    w0 = wstb_cnt; r0 = rstb_cnt;
    wr_reg(16'd5, 8'h77);
    repeat (2) @(negedge clk);
    check("R9 one wstb", 8'(wstb_cnt - w0), 8'd1);
    check("R3 cmd write", cmd_q, 8'h77);
    rd_reg(16'd5, r);
    repeat (2) @(negedge clk);
    check("R9 no wstb on read", 8'(wstb_cnt - w0), 8'd1);
    sts_in = 8'h5A;
    rd_reg(16'd6, r);
    repeat (2) @(negedge clk);
    check("R10 status data", r, 8'h5A);
    check("R10 one rstb", 8'(rstb_cnt - r0), 8'd1);
    wr_reg(16'd6, 8'h11);
    repeat (2) @(negedge clk);
    check("R10 no rstb on write", 8'(rstb_cnt - r0), 8'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ready();
    t_decode();
    t_counter();
    t_irq();
    t_ctl();
    t_strobes();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule